// File: doc/BRIEF.md
# I2C SCL Clock Period Generator

This block produces the serial clock of an I2C bus master. It counts system clock cycles to form the low and high halves of every SCL period, and it times the hold interval that follows a START condition before the first falling edge. Two count pairs are held, one for standard mode and one for fast mode, and a speed-select input picks which pair paces the bus. The reset values of the four counts are derived from the clock frequency parameter, so the block runs at close to nominal rates out of reset.

SCL is open-drain, so the block only ever pulls the line low or lets it go. A low phase starts counting the moment the block pulls SCL low. A high phase starts counting only once the line is seen high through a synchronizer. A slow rise time, or a target that stretches the clock, therefore lengthens the high half instead of shortening it. A byte engine drives the run request. It gets back one-cycle pulses at each rising and falling SCL edge, and a pulse when the START hold has elapsed.

There are five phase states:
- `ST_IDLE`: SCL released.
- `ST_START_HOLD`: SCL released while SDA is held low elsewhere.
- `ST_LOW`: SCL pulled low.
- `ST_RELEASE`: SCL let go, waiting for the line to read high.
- `ST_HIGH`: SCL high and counting.

The transitions are:
- IDLE→START_HOLD when enable and run are both high.
- START_HOLD→LOW when the hold count expires.
- LOW→RELEASE when the low count expires.
- RELEASE→HIGH when the synchronized line reads high.
- HIGH→LOW when the high count expires with run still high.
- HIGH→IDLE when the high count expires with run low.
- Any state→IDLE whenever enable is low.

Top module: `i2c_scl_pacer`

## Requirements
- R1: After reset `scl_drive_low`, `scl_rise`, `scl_fall` and `start_held` are 0. The four counts reset to nonzero values computed from `CLK_KHZ`: standard high 212, standard low 249, fast high 42, fast low 79 at 50 MHz.
- R2: A write with `cfg_we`=1 while `enable`=0 loads `cfg_wdata` into the count chosen by `cfg_sel`. The encoding is 0 = standard high, 1 = standard low, 2 = fast high, 3 = fast low.
- R3: A write while `enable`=1 is ignored, and the timing in use stays unchanged.
- R4: `fast_sel`=0 paces the bus with the standard pair and `fast_sel`=1 with the fast pair.
- R5: When enable and run are seen together in IDLE, SCL stays released for HCNT+3 cycles. SCL is then pulled low, with `scl_fall` and `start_held` pulsing in the first low cycle.
- R6: Every low phase keeps `scl_drive_low`=1 for exactly LCNT+1 cycles, counted from the cycle SCL is pulled low.
- R7: After release, the high phase begins only in the cycle after the synchronized line reads high. The gap is SYNC_STAGES+1 cycles on a free line and longer while the line is held low.
- R8: A high phase lasts HCNT+8 cycles, counting the `scl_rise` cycle. It is followed by a new low phase if run is high, otherwise by IDLE with SCL released. A later run request starts a fresh START hold.
- R9: Dropping `enable` releases SCL in the next cycle and returns to IDLE.
- R10: `scl_rise` and `scl_fall` never pulse together. `start_held` pulses only together with `scl_fall`, and only once per START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; while 1 the counts are locked |
| run | input | 1 | Request to generate clock periods |
| fast_sel | input | 1 | 0 selects the standard pair, 1 the fast pair |
| cfg_we | input | 1 | Count write strobe |
| cfg_sel | input | 2 | Count select: 0 std high, 1 std low, 2 fast high, 3 fast low |
| cfg_wdata | input | CW | Count write value |
| scl_in | input | 1 | Sampled state of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-cycle pulse at the start of a high phase |
| scl_fall | output | 1 | One-cycle pulse at the start of a low phase |
| start_held | output | 1 | One-cycle pulse when the START hold has elapsed |

## Verification
All four outputs are registered from the next state, so each one changes in the same cycle as the state it belongs to. A transition decided at a clock edge is visible on the following falling edge, which is where the bench samples. The hold measurement counts HCNT+3 cycles plus the first low cycle, giving HCNT+4 falling edges from the enabling edge to `start_held`. A released line reaches the phase logic SYNC_STAGES edges after it changes, so `scl_rise` comes SYNC_STAGES+1 cycles after release. The bench feeds `scl_in` from its own predicted drive, updated on the falling edge. It compares a countdown model with the outputs every cycle, and also measures the length of each phase directly.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_START_HOLD = 3'd1,
        ST_LOW        = 3'd2,
        ST_RELEASE    = 3'd3,
        ST_HIGH       = 3'd4
    } phase_e;

    // Count select encoding: bit 1 = mode (1 fast), bit 0 = half (1 low)
    typedef enum logic [1:0] {
        SEL_STD_HI  = 2'd0,
        SEL_STD_LO  = 2'd1,
        SEL_FAST_HI = 2'd2,
        SEL_FAST_LO = 2'd3
    } cnt_sel_e;

    // High-half count: target high time plus 0.3 us fall allowance, minus 3
    function automatic int default_high(input int khz, input bit fast);
        int tenths_us;
        tenths_us = fast ? 6 : 40;
        return (khz * (tenths_us + 3) + 5000) / 10000 - 3;
    endfunction

    // Low-half count: target low time plus 0.3 us fall allowance, minus 1
    function automatic int default_low(input int khz, input bit fast);
        int tenths_us;
        tenths_us = fast ? 13 : 47;
        return (khz * (tenths_us + 3) + 5000) / 10000 - 1;
    endfunction

endpackage

// File: rtl/scl_count_bank.sv
module scl_count_bank #(
    parameter int CW      = 16,
    parameter int CLK_KHZ = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          fast_sel,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] act_hi,
    output logic [CW-1:0] act_lo
);
    localparam int MODES = 2;

    logic [CW-1:0] hi_v [MODES];
    logic [CW-1:0] lo_v [MODES];

    // Writes are only taken while the controller is disabled
    logic wr_ok;
    assign wr_ok = cfg_we && !enable;

    for (genvar m = 0; m < MODES; m++) begin : g_mode
        localparam logic [CW-1:0] HI_RST = CW'(scl_pacer_pkg::default_high(CLK_KHZ, m == 1));
        localparam logic [CW-1:0] LO_RST = CW'(scl_pacer_pkg::default_low(CLK_KHZ, m == 1));
        logic [CW-1:0] hi_r;
        logic [CW-1:0] lo_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_r <= HI_RST;
                lo_r <= LO_RST;
            end else if (wr_ok) begin
                if (cfg_sel == 2'(2 * m))     hi_r <= cfg_wdata;
                if (cfg_sel == 2'(2 * m + 1)) lo_r <= cfg_wdata;
            end
        end

        assign hi_v[m] = hi_r;
        assign lo_v[m] = lo_r;
    end

    assign act_hi = hi_v[fast_sel];
    assign act_lo = lo_v[fast_sel];
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_hi
);
    logic [STAGES-1:0] sh_q;

    // Resets to released so an idle bus reads high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], line_raw};
    end

    assign line_hi = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pacer_pkg::*;
#(
    parameter int CW    = 16,
    parameter int CNT_W = CW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          run,
    input  logic          line_hi,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    output logic          drive_low,
    output logic          rise_pls,
    output logic          fall_pls,
    output logic          hold_done
);
    localparam logic [CNT_W-1:0] HOLD_EXTRA = CNT_W'(2);
    localparam logic [CNT_W-1:0] HIGH_EXTRA = CNT_W'(7);

    phase_e            st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ev_rise, ev_fall, ev_hold;
    logic [CNT_W-1:0]  hold_lim, low_lim, high_lim;

    assign hold_lim = CNT_W'(hi_cnt) + HOLD_EXTRA;
    assign low_lim  = CNT_W'(lo_cnt);
    assign high_lim = CNT_W'(hi_cnt) + HIGH_EXTRA;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q + 1'b1;
        ev_rise = 1'b0;
        ev_fall = 1'b0;
        ev_hold = 1'b0;
        if (!enable) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    cnt_d = '0;
                    if (run) st_d = ST_START_HOLD;
                end
                ST_START_HOLD: begin
                    if (cnt_q == hold_lim) begin
                        st_d    = ST_LOW;
                        cnt_d   = '0;
                        ev_fall = 1'b1;
                        ev_hold = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == low_lim) begin
                        st_d  = ST_RELEASE;
                        cnt_d = '0;
                    end
                end
                ST_RELEASE: begin
                    cnt_d = '0;
                    if (line_hi) begin
                        st_d    = ST_HIGH;
                        ev_rise = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_q == high_lim) begin
                        cnt_d = '0;
                        if (run) begin
                            st_d    = ST_LOW;
                            ev_fall = 1'b1;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output register: outputs line up with the state they describe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_low <= 1'b0;
            rise_pls  <= 1'b0;
            fall_pls  <= 1'b0;
            hold_done <= 1'b0;
        end else begin
            drive_low <= (st_d == ST_LOW);
            rise_pls  <= ev_rise;
            fall_pls  <= ev_fall;
            hold_done <= ev_hold;
        end
    end
endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer #(
    parameter int CW          = 16,
    parameter int CLK_KHZ     = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          run,
    input  logic          fast_sel,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          scl_in,
    output logic          scl_drive_low,
    output logic          scl_rise,
    output logic          scl_fall,
    output logic          start_held
);
    logic [CW-1:0] act_hi;
    logic [CW-1:0] act_lo;
    logic          line_hi;

    scl_count_bank #(.CW(CW), .CLK_KHZ(CLK_KHZ)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fast_sel  (fast_sel),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .act_hi    (act_hi),
        .act_lo    (act_lo)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (scl_in),
        .line_hi  (line_hi)
    );

    scl_phase_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .line_hi   (line_hi),
        .hi_cnt    (act_hi),
        .lo_cnt    (act_lo),
        .drive_low (scl_drive_low),
        .rise_pls  (scl_rise),
        .fall_pls  (scl_fall),
        .hold_done (start_held)
    );
endmodule

// File: rtl/i2c_scl_pacer_chk.sv
module i2c_scl_pacer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          fast_sel,
    input logic          scl_drive_low,
    input logic          scl_rise,
    input logic          scl_fall,
    input logic          start_held,
    input logic          line_hi,
    input logic [CW-1:0] act_hi,
    input logic [CW-1:0] act_lo
);
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall})); // R10

    AST_HOLD_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        start_held |-> scl_fall); // R10

    AST_FALL_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> scl_drive_low); // R6

    AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> !scl_drive_low); // R7

    AST_RISE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> $past(line_hi)); // R7

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low); // R9

    AST_COUNTS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && fast_sel == $past(fast_sel))
            |-> (act_hi == $past(act_hi) && act_lo == $past(act_lo))); // R3
endmodule

bind i2c_scl_pacer i2c_scl_pacer_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .fast_sel      (fast_sel),
    .scl_drive_low (scl_drive_low),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_held    (start_held),
    .line_hi       (line_hi),
    .act_hi        (act_hi),
    .act_lo        (act_lo)
);

// File: tb/tb_i2c_scl_pacer.sv
module tb_i2c_scl_pacer;
    localparam int CW   = 16;
    localparam int SYNC = 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          enable = 0, run = 0, fast_sel = 0, cfg_we = 0;
    logic [1:0]    cfg_sel = 0;
    logic [CW-1:0] cfg_wdata = 0;
    logic          scl_in;
    logic          scl_drive_low, scl_rise, scl_fall, start_held;

    int  errors = 0, checks = 0, cycles = 0;
    int  sd_seen = 0, n_fall = 0;
    bit  stretch = 0, m_drive_seen = 0, finished = 0;

    always #10 clk = ~clk;

    assign scl_in = !(m_drive_seen || stretch);

    i2c_scl_pacer #(.CW(CW), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .fast_sel(fast_sel),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_held(start_held)
    );

    // Reference model: countdown of cycles left in each phase
    int m_state, m_left;
    int m_reg [4];
    bit m_drive, m_rise, m_fall, m_sd;
    bit hist [$];

    always @(posedge clk or negedge rst_n) begin
        int  hc, lc;
        bit  seen;
        if (!rst_n) begin
            m_state = 0; m_left = 0;
            m_reg[0] = 212; m_reg[1] = 249; m_reg[2] = 42; m_reg[3] = 79;
            m_drive = 0; m_rise = 0; m_fall = 0; m_sd = 0;
            hist = {};
            for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);
        end else begin
            hc = fast_sel ? m_reg[2] : m_reg[0];
            lc = fast_sel ? m_reg[3] : m_reg[1];
            seen = hist.pop_front();
            hist.push_back(scl_in);
            if (cfg_we && !enable) m_reg[cfg_sel] = int'(cfg_wdata);
            m_rise = 0; m_fall = 0; m_sd = 0;
            if (!enable) m_state = 0;
            else case (m_state)
                0: if (run) begin m_state = 1; m_left = hc + 3; end
                1: if (m_left == 1) begin
                       m_state = 2; m_left = lc + 1; m_fall = 1; m_sd = 1;
                   end else m_left--;
                2: if (m_left == 1) m_state = 3; else m_left--;
                3: if (seen) begin m_state = 4; m_left = hc + 8; m_rise = 1; end
                default: if (m_left == 1) begin
                       if (run) begin m_state = 2; m_left = lc + 1; m_fall = 1; end
                       else m_state = 0;
                   end else m_left--;
            endcase
            m_drive = (m_state == 2);
        end
    end

    always @(negedge clk) m_drive_seen <= m_drive;

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        string tag;
        if (rst_n && !finished) begin
            cycles++;
            if (start_held) sd_seen++;
            if (scl_fall) n_fall++;
            case (m_state)
                1: tag = "R5"; 2: tag = "R6"; 3: tag = "R7"; 4: tag = "R8";
                default: tag = "R9";
            endcase
            checks++;
            if ({scl_drive_low, scl_rise, scl_fall, start_held} != {m_drive, m_rise, m_fall, m_sd}) begin
                errors++;
                $display("FAIL %s cycle %0d: outputs %b expected %b", tag, cycles,
                         {scl_drive_low, scl_rise, scl_fall, start_held},
                         {m_drive, m_rise, m_fall, m_sd});
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cnt(input int sel, input int val);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = CW'(val);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Enable with run held and count falling edges until start_held
    task automatic start_hold(output int n);
        enable = 1; n = 0;
        do begin @(negedge clk); n++; end while (!start_held);
    endtask

    // One SCL period: low length, release-to-rise gap, high length
    task automatic phase_cycle(input int hold_extra, output int lo, output int gap, output int hi);
        while (!scl_fall) @(negedge clk);
        if (hold_extra > 0) stretch = 1;
        lo = 0;
        while (scl_drive_low) begin lo++; @(negedge clk); end
        gap = 1;
        if (hold_extra > 0) begin
            repeat (hold_extra - 1) begin @(negedge clk); gap++; end
            stretch = 0;
        end
        forever begin @(negedge clk); if (scl_rise) break; gap++; end
        hi = 0;
        do begin hi++; @(negedge clk); end while (!scl_fall);
    endtask

    initial begin
        int n, lo, gap, hi, f0;
        repeat (3) @(negedge clk);
        check("R1 drive", int'(scl_drive_low), 0);
        check("R1 pulses", int'({scl_rise, scl_fall, start_held}), 0);
        rst_n = 1;
        @(negedge clk);
        run = 1;
        // R1 standard defaults
        start_hold(n);             check("R1 std hold", n, 216);
        phase_cycle(0, lo, gap, hi);
        check("R1 std low", lo, 250); check("R7 gap", gap, SYNC + 1); check("R1 std high", hi, 220);
        enable = 0; @(negedge clk);
        // R1 / R4 fast defaults
        fast_sel = 1;
        start_hold(n);             check("R4 fast default hold", n, 46);
        phase_cycle(0, lo, gap, hi);
        check("R1 fast low", lo, 80); check("R1 fast high", hi, 50);
        enable = 0; @(negedge clk);
        // R2 programmed standard pair
        fast_sel = 0;
        write_cnt(0, 5); write_cnt(1, 9);
        start_hold(n);             check("R2 hold", n, 9);
        phase_cycle(0, lo, gap, hi);
        check("R2 low", lo, 10); check("R7 gap", gap, SYNC + 1); check("R2 high", hi, 13);
        // R3 writes ignored while enabled
        write_cnt(1, 30); write_cnt(0, 1);
        phase_cycle(0, lo, gap, hi);
        check("R3 low", lo, 10); check("R3 high", hi, 13);
        // R7 stretched line
        phase_cycle(10, lo, gap, hi);
        check("R6 low", lo, 10); check("R7 stretched gap", gap, 10 + SYNC); check("R8 high", hi, 13);
        // R9 disable releases
        while (!scl_fall) @(negedge clk);
        enable = 0; @(negedge clk);
        check("R9 release", int'(scl_drive_low), 0);
        // R4 fast pair programmed
        write_cnt(2, 2); write_cnt(3, 3);
        fast_sel = 1; sd_seen = 0;
        start_hold(n);             check("R5 fast hold", n, 6);
        phase_cycle(0, lo, gap, hi);
        check("R4 low", lo, 4); check("R4 high", hi, 10);
        phase_cycle(0, lo, gap, hi);
        check("R10 start_held once", sd_seen, 1);
        // R8 stop after the high phase
        while (!scl_fall) @(negedge clk);
        run = 0;
        while (!scl_rise) @(negedge clk);
        f0 = n_fall;
        repeat (40) @(negedge clk);
        check("R8 no fall after stop", n_fall - f0, 0);
        check("R8 released", int'(scl_drive_low), 0);
        run = 1; n = 0;
        do begin @(negedge clk); n++; end while (!start_held);
        check("R8 fresh START hold", n, 6);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule